// File: doc/BRIEF.md
# Phase-Shifted Bridge Gate Timer

This block turns a system clock into six digital gate enables for a phase-shifted full-bridge converter. Two outputs drive the leading bridge leg, two drive the lagging leg, and two drive the secondary synchronous rectifiers. The block splits time into half-cycles of a programmable length. Two half-cycles make one switching period, so the internal half-cycle rate is twice the output switching frequency. Each bridge leg spends alternate half-cycles on its two complementary switches. The lagging leg switches a programmable number of ticks into every half-cycle. The overlap of the diagonal switches therefore sets the power pulse width.

Every transition is separated by a dead time. Each dead time is computed from a base value and a term set by the load code. The two bridge legs have their own bases and share one gain, and their dead time shortens as the load code rises. The rectifier delay has its own base and gain, and it lengthens as the load code rises. The half length, the phase shift and all three dead times are captured at the start of each half-cycle. A new demand therefore never disturbs a transition already under way.

Top module: `psfb_gate_timer`

## Requirements
- R1: While `rst` is high, or from the first clock edge that samples `en` low, all six outputs are low.
- R2: After `en` rises, the first half-cycle is an even one. `leg1_p` is the first leading-leg output to go high. `rect_n` stays low for the whole of that first half-cycle.
- R3: A half-cycle lasts `half_period` ticks, with values below 2 treated as 2, so the switching period is twice that length. `leg1_p` conducts in even half-cycles and `leg1_n` in odd ones. Each output goes high a leading-leg dead time after its half-cycle starts, so the rising edges of `leg1_p` are two half-cycles apart.
- R4: Bridge dead time in ticks = base − ((gain × load_code) >> 8), floored at 1. The base and gain are 8-bit. A gain of 0 gives exactly the base, or 1 when the base is 0.
- R5: The lagging leg switches `phase_shift` ticks after each half-cycle starts, with the shift clamped to half_period − 1. `leg2_n` is the side on before that point in an even half-cycle, and `leg2_p` is on after it. The incoming side rises one lagging-leg dead time after the switch. `leg1_p` and `leg2_n` are high together for (shift − leading-leg dead time) ticks per even half-cycle.
- R6: The lagging leg uses its own base, `dt_leg2_base`, with the same gain and formula as R4.
- R7: Rectifier delay in ticks = base + ((gain × load_code) >> 8), saturated to the range 1 to 255.
- R8: `rect_p` is high for all of each even half-cycle and falls the rectifier delay after `leg1_p` falls. `rect_n` behaves the same way for odd half-cycles and `leg1_n`. Whenever `leg1_p` is high, `rect_p` is high, and whenever `leg1_n` is high, `rect_n` is high.
- R9: The half length, shift and dead times are sampled only at a half-cycle start. Input changes made inside a half-cycle take effect from the next half-cycle.
- R10: The two outputs of a leg are never high together. When one of them falls, the other is low in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low forces all outputs low |
| half_period | input | 16 | Ticks per half-cycle |
| phase_shift | input | 16 | Lagging-leg switch point in ticks within a half-cycle |
| load_code | input | 8 | Digitized load current |
| dt_leg1_base | input | 8 | Leading-leg base dead time |
| dt_leg2_base | input | 8 | Lagging-leg base dead time |
| dt_rect_base | input | 8 | Rectifier base delay |
| dt_bridge_gain | input | 8 | Load weight for both bridge legs (n/256) |
| dt_rect_gain | input | 8 | Load weight for the rectifier delay (n/256) |
| leg1_p | output | 1 | Leading leg, even-half switch |
| leg1_n | output | 1 | Leading leg, odd-half switch |
| leg2_p | output | 1 | Lagging leg, switch that follows leg1_p diagonally |
| leg2_n | output | 1 | Lagging leg, switch that follows leg1_n diagonally |
| rect_p | output | 1 | Rectifier paired with leg1_p |
| rect_n | output | 1 | Rectifier paired with leg1_n |

## Verification
The properties assume that every input changes synchronously to the clock and that reset is applied before the first enable. They also assume that `en` stays low for at least one sampled edge before it rises again, so the start sequence is seen cleanly. The stimulus drives all inputs on the falling clock edge. It changes `load_code` at random inside half-cycles and re-targets the period and shift while running. This exercises the capture-at-half-start rule without ever breaking those assumptions. Directed cases push the arithmetic to both saturation limits, push the shift past the half length, and push the half length below its floor.

// File: rtl/psfb_pkg.sv
package psfb_pkg;
  // Direction in which the load term moves a dead time.
  typedef enum logic {
    DT_SHRINK = 1'b0,
    DT_GROW   = 1'b1
  } dt_dir_e;
endpackage

// File: rtl/psfb_dt_unit.sv
module psfb_dt_unit
  import psfb_pkg::*;
#(
  parameter int      DT_W   = 8,
  parameter int      LOAD_W = 8,
  parameter int      GAIN_W = 8,
  parameter dt_dir_e DIR    = DT_SHRINK
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic [DT_W-1:0]   base,
  input  logic [GAIN_W-1:0] gain,
  input  logic [LOAD_W-1:0] load,
  output logic [DT_W-1:0]   dt_o
);
  localparam int PW = GAIN_W + LOAD_W;
  localparam int SW = ((GAIN_W > DT_W) ? GAIN_W : DT_W) + 1;
  localparam logic [SW-1:0] DT_MAX = SW'((1 << DT_W) - 1);
  localparam logic [SW-1:0] DT_MIN = SW'(1);

  logic [PW-1:0] prod;
  logic [SW-1:0] term;
  logic [SW-1:0] base_x;
  logic [SW-1:0] raw;
  logic [SW-1:0] sat;

  assign prod   = PW'(gain) * PW'(load);
  assign term   = SW'(prod >> LOAD_W);
  assign base_x = SW'(base);

  generate
    if (DIR == DT_SHRINK) begin : g_shrink
      assign raw = (term >= base_x) ? DT_MIN : (base_x - term);
    end else begin : g_grow
      assign raw = base_x + term;
    end
  endgenerate

  assign sat = (raw > DT_MAX) ? DT_MAX : ((raw < DT_MIN) ? DT_MIN : raw);

  // Captured once per half-cycle only.
  always_ff @(posedge clk) begin
    if (rst) begin
      dt_o <= DT_W'(1);
    end else if (load_en) begin
      dt_o <= sat[DT_W-1:0];
    end
  end
endmodule

// File: rtl/psfb_half_sched.sv
module psfb_half_sched #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CNT_W-1:0] half_in,
  input  logic [CNT_W-1:0] shift_in,
  output logic             run_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             phase_o,
  output logic             first_o,
  output logic             leg2_sel_o,
  output logic [CNT_W-1:0] leg2_el_o,
  output logic             half_start_o
);
  localparam logic [CNT_W-1:0] HALF_MIN = CNT_W'(2);
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);
  localparam logic [CNT_W-1:0] EL_MAX   = '1;

  logic             run_q, run_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ph_q, ph_d;
  logic             first_q, first_d;
  logic [CNT_W-1:0] hp_q, hp_d;
  logic [CNT_W-1:0] sh_q, sh_d;
  logic             sel2_q, sel2_d;
  logic [CNT_W-1:0] el2_q, el2_d;
  logic             new_half;
  logic             start;
  logic             ev2;

  always_comb begin
    run_d    = run_q;
    cnt_d    = cnt_q;
    ph_d     = ph_q;
    first_d  = first_q;
    hp_d     = hp_q;
    sh_d     = sh_q;
    sel2_d   = sel2_q;
    el2_d    = el2_q;
    new_half = 1'b0;
    start    = 1'b0;
    ev2      = 1'b0;
    if (!en) begin
      run_d   = 1'b0;
      cnt_d   = '0;
      ph_d    = 1'b0;
      first_d = 1'b0;
      sel2_d  = 1'b0;
      el2_d   = '0;
    end else begin
      if (!run_q) begin
        run_d    = 1'b1;
        cnt_d    = '0;
        ph_d     = 1'b0;
        first_d  = 1'b1;
        new_half = 1'b1;
        start    = 1'b1;
      end else if (cnt_q == hp_q - ONE) begin
        cnt_d    = '0;
        ph_d     = ~ph_q;
        first_d  = 1'b0;
        new_half = 1'b1;
      end else begin
        cnt_d = cnt_q + ONE;
      end
      if (new_half) begin
        hp_d = (half_in < HALF_MIN) ? HALF_MIN : half_in;
        sh_d = (shift_in > hp_d - ONE) ? (hp_d - ONE) : shift_in;
      end
      ev2 = (cnt_d == sh_d);
      if (ev2) begin
        sel2_d = ~ph_d;
        el2_d  = '0;
      end else if (start) begin
        sel2_d = 1'b0;
        el2_d  = '0;
      end else if (el2_q != EL_MAX) begin
        el2_d = el2_q + ONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      cnt_q   <= '0;
      ph_q    <= 1'b0;
      first_q <= 1'b0;
      hp_q    <= HALF_MIN;
      sh_q    <= '0;
      sel2_q  <= 1'b0;
      el2_q   <= '0;
    end else begin
      run_q   <= run_d;
      cnt_q   <= cnt_d;
      ph_q    <= ph_d;
      first_q <= first_d;
      hp_q    <= hp_d;
      sh_q    <= sh_d;
      sel2_q  <= sel2_d;
      el2_q   <= el2_d;
    end
  end

  assign run_o        = run_q;
  assign cnt_o        = cnt_q;
  assign phase_o      = ph_q;
  assign first_o      = first_q;
  assign leg2_sel_o   = sel2_q;
  assign leg2_el_o    = el2_q;
  assign half_start_o = new_half;
endmodule

// File: rtl/psfb_leg_out.sv
module psfb_leg_out #(
  parameter int CNT_W = 16,
  parameter int DT_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             run,
  input  logic             sel,
  input  logic [CNT_W-1:0] elapsed,
  input  logic [DT_W-1:0]  dt,
  output logic             out0,
  output logic             out1
);
  logic on_c;

  assign on_c = en && run && (elapsed >= CNT_W'(dt));

  always_ff @(posedge clk) begin
    if (rst) begin
      out0 <= 1'b0;
      out1 <= 1'b0;
    end else begin
      out0 <= on_c && !sel;
      out1 <= on_c && sel;
    end
  end
endmodule

// File: rtl/psfb_gate_timer.sv
module psfb_gate_timer
  import psfb_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DT_W   = 8,
  parameter int LOAD_W = 8,
  parameter int GAIN_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [CNT_W-1:0]  half_period,
  input  logic [CNT_W-1:0]  phase_shift,
  input  logic [LOAD_W-1:0] load_code,
  input  logic [DT_W-1:0]   dt_leg1_base,
  input  logic [DT_W-1:0]   dt_leg2_base,
  input  logic [DT_W-1:0]   dt_rect_base,
  input  logic [GAIN_W-1:0] dt_bridge_gain,
  input  logic [GAIN_W-1:0] dt_rect_gain,
  output logic              leg1_p,
  output logic              leg1_n,
  output logic              leg2_p,
  output logic              leg2_n,
  output logic              rect_p,
  output logic              rect_n
);
  localparam int N_DT   = 3;
  localparam int N_LEG  = 2;
  localparam int RECT_I = N_DT - 1;

  logic             run;
  logic [CNT_W-1:0] cnt;
  logic             phase;
  logic             first;
  logic             sel2;
  logic [CNT_W-1:0] el2;
  logic             half_start;

  psfb_half_sched #(.CNT_W(CNT_W)) u_sched (
    .clk          (clk),
    .rst          (rst),
    .en           (en),
    .half_in      (half_period),
    .shift_in     (phase_shift),
    .run_o        (run),
    .cnt_o        (cnt),
    .phase_o      (phase),
    .first_o      (first),
    .leg2_sel_o   (sel2),
    .leg2_el_o    (el2),
    .half_start_o (half_start)
  );

  // Dead-time channels: 0 leading leg, 1 lagging leg, 2 rectifier.
  logic [DT_W-1:0] dt_base [N_DT];
  logic [DT_W-1:0] dt_val  [N_DT];

  assign dt_base[0] = dt_leg1_base;
  assign dt_base[1] = dt_leg2_base;
  assign dt_base[2] = dt_rect_base;

  generate
    for (genvar i = 0; i < N_DT; i++) begin : g_dt
      localparam dt_dir_e CH_DIR = (i == RECT_I) ? DT_GROW : DT_SHRINK;
      psfb_dt_unit #(
        .DT_W   (DT_W),
        .LOAD_W (LOAD_W),
        .GAIN_W (GAIN_W),
        .DIR    (CH_DIR)
      ) u_dt (
        .clk     (clk),
        .rst     (rst),
        .load_en (half_start),
        .base    (dt_base[i]),
        .gain    ((i == RECT_I) ? dt_rect_gain : dt_bridge_gain),
        .load    (load_code),
        .dt_o    (dt_val[i])
      );
    end
  endgenerate

  // Bridge legs: leg 0 follows the half-cycle counter, leg 1 the shifted switch.
  logic             leg_sel [N_LEG];
  logic [CNT_W-1:0] leg_el  [N_LEG];
  logic             leg_o0  [N_LEG];
  logic             leg_o1  [N_LEG];

  assign leg_sel[0] = phase;
  assign leg_el[0]  = cnt;
  assign leg_sel[1] = sel2;
  assign leg_el[1]  = el2;

  generate
    for (genvar j = 0; j < N_LEG; j++) begin : g_leg
      psfb_leg_out #(.CNT_W(CNT_W), .DT_W(DT_W)) u_leg (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .run     (run),
        .sel     (leg_sel[j]),
        .elapsed (leg_el[j]),
        .dt      (dt_val[j]),
        .out0    (leg_o0[j]),
        .out1    (leg_o1[j])
      );
    end
  endgenerate

  assign leg1_p = leg_o0[0];
  assign leg1_n = leg_o1[0];
  assign leg2_n = leg_o0[1];
  assign leg2_p = leg_o1[1];

  // Rectifiers: on through their own half, held a delay into the next one.
  logic tail;
  logic rp_q, rn_q;

  assign tail = !first && (cnt < CNT_W'(dt_val[RECT_I]));

  always_ff @(posedge clk) begin
    if (rst) begin
      rp_q <= 1'b0;
      rn_q <= 1'b0;
    end else begin
      rp_q <= en && run && (!phase || tail);
      rn_q <= en && run && (phase || tail);
    end
  end

  assign rect_p = rp_q;
  assign rect_n = rn_q;
endmodule

// File: rtl/psfb_gate_timer_chk.sv
module psfb_gate_timer_chk (
  input logic clk,
  input logic rst,
  input logic en,
  input logic leg1_p,
  input logic leg1_n,
  input logic leg2_p,
  input logic leg2_n,
  input logic rect_p,
  input logic rect_n
);
  p_quiet_when_off_r1: assert property (@(posedge clk) disable iff (rst)
    !en |=> !(leg1_p || leg1_n || leg2_p || leg2_n || rect_p || rect_n));

  p_start_even_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(en) |=> (!leg1_n && !rect_n));

  p_leg1_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(leg1_p && leg1_n));

  p_leg2_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(leg2_p && leg2_n));

  p_leg1_gap_r10: assert property (@(posedge clk) disable iff (rst)
    ($fell(leg1_p) |-> !leg1_n) and ($fell(leg1_n) |-> !leg1_p));

  p_leg2_gap_r10: assert property (@(posedge clk) disable iff (rst)
    ($fell(leg2_p) |-> !leg2_n) and ($fell(leg2_n) |-> !leg2_p));

  p_rect_cover_r8: assert property (@(posedge clk) disable iff (rst)
    (leg1_p |-> rect_p) and (leg1_n |-> rect_n));
endmodule

bind psfb_gate_timer psfb_gate_timer_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .en     (en),
  .leg1_p (leg1_p),
  .leg1_n (leg1_n),
  .leg2_p (leg2_p),
  .leg2_n (leg2_n),
  .rect_p (rect_p),
  .rect_n (rect_n)
);

// File: tb/tb_psfb_gate_timer.sv
module tb_psfb_gate_timer;
  logic        clk = 1'b0;
  logic        rst;
  logic        en;
  logic [15:0] half_period, phase_shift;
  logic [7:0]  load_code, b1, b2, b3, gb, gr;
  logic        leg1_p, leg1_n, leg2_p, leg2_n, rect_p, rect_n;
  logic [5:0]  outs;

  always #2.5 clk = ~clk;

  psfb_gate_timer dut (
    .clk(clk), .rst(rst), .en(en), .half_period(half_period), .phase_shift(phase_shift),
    .load_code(load_code), .dt_leg1_base(b1), .dt_leg2_base(b2), .dt_rect_base(b3),
    .dt_bridge_gain(gb), .dt_rect_gain(gr),
    .leg1_p(leg1_p), .leg1_n(leg1_n), .leg2_p(leg2_p), .leg2_n(leg2_n),
    .rect_p(rect_p), .rect_n(rect_n));

  // 0 leg1_p, 1 leg1_n, 2 leg2_p, 3 leg2_n, 4 rect_p, 5 rect_n
  assign outs = {rect_n, rect_p, leg2_n, leg2_p, leg1_n, leg1_p};

  int n_run = 0, n_fail = 0, cyc = 0;
  bit cmp_on = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int bdt(input int base, input int g, input int l);
    int v = base - ((g * l) >> 8);
    return (v < 1) ? 1 : v;
  endfunction

  function automatic int rdt(input int base, input int g, input int l);
    int v = base + ((g * l) >> 8);
    if (v > 255) v = 255;
    return (v < 1) ? 1 : v;
  endfunction

  // Timeline model built from the requirements.
  int m_cnt, m_H, m_s, m_dab, m_dcd, m_dsr, m_el2;
  bit m_run, m_ph, m_first, m_sel2;
  bit e_l1p, e_l1n, e_l2p, e_l2n, e_rp, e_rn;

  always @(posedge clk) begin
    bit newh, strt;
    if (rst) begin
      m_run = 0; m_cnt = 0; m_ph = 0; m_first = 0; m_sel2 = 0; m_el2 = 0;
      m_H = 2; m_s = 0; m_dab = 1; m_dcd = 1; m_dsr = 1;
      {e_l1p, e_l1n, e_l2p, e_l2n, e_rp, e_rn} = '0;
    end else begin
      e_l1p = en && m_run && !m_ph && (m_cnt >= m_dab);
      e_l1n = en && m_run && m_ph && (m_cnt >= m_dab);
      e_l2n = en && m_run && !m_sel2 && (m_el2 >= m_dcd);
      e_l2p = en && m_run && m_sel2 && (m_el2 >= m_dcd);
      e_rp  = en && m_run && (!m_ph || (!m_first && m_cnt < m_dsr));
      e_rn  = en && m_run && (m_ph || (!m_first && m_cnt < m_dsr));
      if (!en) begin
        m_run = 0; m_cnt = 0; m_ph = 0; m_first = 0; m_sel2 = 0; m_el2 = 0;
      end else begin
        newh = 0; strt = 0;
        if (!m_run) begin
          m_run = 1; m_cnt = 0; m_ph = 0; m_first = 1; newh = 1; strt = 1;
        end else if (m_cnt == m_H - 1) begin
          m_cnt = 0; m_ph = !m_ph; m_first = 0; newh = 1;
        end else m_cnt++;
        if (newh) begin
          m_H   = (half_period < 2) ? 2 : int'(half_period);
          m_s   = (int'(phase_shift) > m_H - 1) ? m_H - 1 : int'(phase_shift);
          m_dab = bdt(b1, gb, load_code);
          m_dcd = bdt(b2, gb, load_code);
          m_dsr = rdt(b3, gr, load_code);
        end
        if (m_cnt == m_s) begin m_sel2 = !m_ph; m_el2 = 0; end
        else if (strt) begin m_sel2 = 0; m_el2 = 0; end
        else if (m_el2 < 65535) m_el2++;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && cmp_on) begin
      chk({leg1_p, leg1_n} == {e_l1p, e_l1n}, "R3 R4 R9 leading leg", {leg1_p, leg1_n}, {e_l1p, e_l1n});
      chk({leg2_p, leg2_n} == {e_l2p, e_l2n}, "R5 R6 lagging leg", {leg2_p, leg2_n}, {e_l2p, e_l2n});
      chk({rect_p, rect_n} == {e_rp, e_rn}, "R7 R8 rectifiers", {rect_p, rect_n}, {e_rp, e_rn});
      chk(!(leg1_p && leg1_n) && !(leg2_p && leg2_n), "R10 overlap", {leg1_p, leg1_n, leg2_p, leg2_n}, 0);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(0, "watchdog", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic cfg(input int h, input int s, input int x1, input int x2, input int x3,
                     input int g1, input int g2, input int l);
    @(negedge clk);
    en = 0;
    @(negedge clk);
    half_period = 16'(h); phase_shift = 16'(s);
    b1 = 8'(x1); b2 = 8'(x2); b3 = 8'(x3); gb = 8'(g1); gr = 8'(g2); load_code = 8'(l);
    @(negedge clk);
    en = 1;
  endtask

  // Fall of outs[f], then ticks until outs[t] reaches level lv.
  task automatic meas(input int f, input int t, input bit lv, output int n);
    int g = 0;
    while (outs[f] !== 1'b1 && g < 3000) begin @(negedge clk); g++; end
    while (outs[f] !== 1'b0 && g < 3000) begin @(negedge clk); g++; end
    n = 0;
    while (outs[t] !== lv && g < 3000) begin @(negedge clk); n++; g++; end
  endtask

  task automatic rise_period(input int i, output int n);
    int g = 0;
    while (outs[i] !== 1'b0 && g < 3000) begin @(negedge clk); g++; end
    while (outs[i] !== 1'b1 && g < 3000) begin @(negedge clk); g++; end
    n = 0;
    do begin @(negedge clk); n++; g++; end while (outs[i] !== 1'b0 && g < 3000);
    while (outs[i] !== 1'b1 && g < 3000) begin @(negedge clk); n++; g++; end
  endtask

  task automatic overlap(output int n);
    int g = 0;
    while (leg1_p !== 1'b0 && g < 3000) begin @(negedge clk); g++; end
    while (leg1_p !== 1'b1 && g < 3000) begin @(negedge clk); g++; end
    n = 0;
    while (leg1_p && leg2_n && g < 3000) begin n++; g++; @(negedge clk); end
  endtask

  initial begin
    int v, h, first_hi;
    bit rn_seen;
    void'($urandom(32'd2024));
    rst = 1; en = 0; half_period = 16'd20; phase_shift = 16'd10; load_code = 0;
    b1 = 4; b2 = 4; b3 = 4; gb = 0; gr = 0;
    repeat (4) @(negedge clk);
    chk(outs == 6'b0, "R1 reset state", outs, 0);
    rst = 0;
    @(negedge clk);
    cmp_on = 1;

    // R2 first half starts on leg1_p, rect_n quiet
    cfg(24, 12, 4, 4, 6, 0, 0, 0);
    first_hi = 0; rn_seen = 0;
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      if (first_hi == 0 && leg1_p) first_hi = 1;
      if (first_hi == 0 && leg1_n) first_hi = 2;
      if (rect_n) rn_seen = 1;
    end
    chk(first_hi == 1, "R2 first leading output", first_hi, 1);
    chk(!rn_seen, "R2 rect_n in first half", rn_seen, 0);

    // R4 fixed, floor, mid
    meas(1, 0, 1'b1, v); chk(v == 4, "R4 gain zero", v, 4);
    cfg(40, 20, 3, 3, 6, 255, 0, 255);
    meas(1, 0, 1'b1, v); chk(v == 1, "R4 floor", v, 1);
    cfg(60, 25, 80, 70, 6, 128, 0, 100);
    meas(1, 0, 1'b1, v); chk(v == 30, "R4 load term", v, 30);
    // R6 lagging leg with shared gain
    meas(3, 2, 1'b1, v); chk(v == 20, "R6 lagging dead time", v, 20);

    // R7 rectifier delay
    cfg(150, 40, 5, 5, 10, 0, 200, 128);
    meas(0, 4, 1'b0, v); chk(v == 110, "R7 load term", v, 110);
    cfg(300, 40, 5, 5, 200, 0, 255, 255);
    meas(0, 4, 1'b0, v); chk(v == 255, "R7 ceiling", v, 255);
    cfg(30, 10, 5, 5, 0, 0, 0, 0);
    meas(1, 5, 1'b0, v); chk(v == 1, "R7 floor", v, 1);

    // R5 pulse width and shift clamp
    cfg(50, 30, 5, 5, 4, 0, 0, 0);
    overlap(v); chk(v == 25, "R5 pulse width", v, 25);
    cfg(50, 80, 5, 5, 4, 0, 0, 0);
    overlap(v); chk(v == 44, "R5 shift clamp", v, 44);

    // R3 period and half floor
    cfg(37, 10, 3, 3, 4, 0, 0, 0);
    rise_period(0, v); chk(v == 74, "R3 period", v, 74);
    cfg(1, 0, 1, 1, 1, 0, 0, 0);
    rise_period(0, h); chk(h == 4, "R3 half floor", h, 4);

    // R9 mid-half change is deferred
    cfg(60, 30, 10, 10, 4, 0, 0, 0);
    meas(1, 0, 1'b1, v);
    chk(v == 10, "R9 before change", v, 10);
    cfg(60, 30, 10, 10, 4, 0, 0, 0);
    begin
      int g = 0;
      while (leg1_n !== 1'b1 && g < 3000) begin @(negedge clk); g++; end
      while (leg1_n !== 1'b0 && g < 3000) begin @(negedge clk); g++; end
      b1 = 40;
      v = 0;
      while (leg1_p !== 1'b1 && g < 3000) begin @(negedge clk); v++; g++; end
    end
    chk(v == 10, "R9 change inside half", v, 10);
    meas(0, 1, 1'b1, v); chk(v == 40, "R9 next half", v, 40);

    // R1 disable mid-run
    repeat (17) @(negedge clk);
    en = 0;
    @(negedge clk);
    chk(outs == 6'b0, "R1 disable", outs, 0);
    v = 0;
    repeat (10) begin @(negedge clk); if (outs != 0) v++; end
    chk(v == 0, "R1 stays low", v, 0);

    // Random segments
    for (int seg = 0; seg < 10; seg++) begin
      h = $urandom_range(16, 90);
      cfg(h, $urandom_range(0, h + 4), $urandom_range(0, 40), $urandom_range(0, 40),
          $urandom_range(0, 60), $urandom_range(0, 255), $urandom_range(0, 255), $urandom_range(0, 255));
      for (int c = 0; c < 500; c++) begin
        @(negedge clk);
        load_code = 8'($urandom_range(0, 255));
        if (c == 250) begin
          h = $urandom_range(8, 90);
          half_period = 16'(h);
          phase_shift = 16'($urandom_range(0, h));
        end
      end
    end

    cmp_on = 0;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule